// File: doc/BRIEF.md
# Falling-Edge DMA Request Controller

This block is the front end of one DMA channel. It watches an active-low request line that is synchronous to the bus clock. Software writes an enable bit together with a transfer count. While the channel is enabled and acceptance is armed, a low sample on the request line sets a pending request. The sequencer takes that request, clears it, waits a fixed minimum latency and then runs one source read strobe followed by one destination write strobe. Each strobe is held until its acknowledge arrives.

Acceptance stays blocked from the moment the sequencer takes a request until the write completes. After that, acceptance re-arms only if the request line has been sampled high at some point since the request was taken. A line held low for a long time therefore produces one transfer and no more. Each completed write lowers the remaining count by one. When the count runs out, the block drops its enable and raises a done flag. If software clears the enable, any request that has not started is dropped, and the block goes idle once the bus strobe in progress has been acknowledged.

Top module: `dma_edge_req_ctrl`

## Requirements
- R1: After reset, rd_req, wr_req, req_pending, chan_en and xfer_done are all 0.
- R2: While chan_en is 0 the request line is ignored: req_pending is 0 in the cycle after any cycle in which chan_en was 0.
- R3: After an enable write (en_wr=1, en_wdata=1, count_load nonzero), chan_en is 1 after that clock edge. The request line is first sampled on the following edge, and a low sample there sets req_pending.
- R4: A pending request is taken and cleared on the edge after the one that set it, when the sequencer is idle.
- R5: rd_req rises MIN_LAT (default 3) clock edges after the edge that set req_pending, and never sooner.
- R6: Each taken request produces exactly one read handshake followed by exactly one write handshake. A high sample seen between taking the request and the end of the write re-arms acceptance, so a low level present right after the write sets a new request.
- R7: While a read or write strobe is active no request is accepted. A request line held low without a high sample after the request was taken causes no further transfer.
- R8: The write that lowers the remaining count from 1 to 0 clears chan_en and sets xfer_done on the same edge. No further transfers follow.
- R9: rd_req and wr_req stay high until the matching acknowledge is sampled, for any number of wait cycles, and are never high together.
- R10: A disable write (en_wr=1, en_wdata=0) clears chan_en on that edge. If a read strobe is in progress, it completes and no write follows.
- R11: An enable write with count_load equal to 0 leaves chan_en at 0. An accepted enable write clears xfer_done.

Parameters: CNT_W (default 16) sets the transfer counter width. MIN_LAT (at least 2, default 3) sets the request-to-read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_wr | input | 1 | Strobe for a write to the enable control |
| en_wdata | input | 1 | Enable value written when en_wr is high |
| count_load | input | CNT_W | Transfer count loaded by an accepted enable write |
| dreq_n | input | 1 | Active-low transfer request, synchronous to clk |
| rd_req | output | 1 | Source read strobe, held until rd_ack |
| rd_ack | input | 1 | Read cycle complete |
| wr_req | output | 1 | Destination write strobe, held until wr_ack |
| wr_ack | input | 1 | Write cycle complete |
| req_pending | output | 1 | A request has been latched and not yet taken |
| chan_en | output | 1 | Channel enabled |
| xfer_done | output | 1 | Transfer count reached zero |

## Verification
The checker assumes that rd_ack and wr_ack are pulsed only while the matching strobe is high, and for a single cycle. It also assumes that dreq_n and the enable controls change only between clock edges, and that enable writes are issued only when the channel is idle. The bench's responder raises an acknowledge only after it has seen the strobe, and drops it on the next cycle. All inputs are driven on the falling clock edge, and the enable is reprogrammed only after the previous transfer sequence has settled.

// File: rtl/dma_edge_pkg.sv
package dma_edge_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_READ  = 2'd2,
    SEQ_WRITE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dma_req_latch.sv
// Request capture: holds a pending request and the re-arm condition.
module dma_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic seq_idle,
  input  logic arm_load,
  input  logic dreq_n,
  output logic req_pending,
  output logic activate
);

  logic pend_q, pend_d;
  logic seen_hi_q, seen_hi_d;
  logic accept;

  // take the request only when the sequencer can start at once
  assign activate = pend_q & seq_idle & chan_en;
  assign accept   = chan_en & seq_idle & ~pend_q & seen_hi_q & ~dreq_n;

  always_comb begin
    pend_d = chan_en & ~activate & (pend_q | accept);
    if (arm_load) begin
      seen_hi_d = 1'b1;
    end else if (activate) begin
      seen_hi_d = 1'b0;
    end else begin
      seen_hi_d = seen_hi_q | (chan_en & dreq_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      seen_hi_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      seen_hi_q <= seen_hi_d;
    end
  end

  assign req_pending = pend_q;

endmodule

// File: rtl/dma_cycle_seq.sv
// Transfer sequencer: latency wait, read handshake, write handshake.
module dma_cycle_seq
  import dma_edge_pkg::*;
#(
  parameter int MIN_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic chan_en,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic rd_req,
  output logic wr_req,
  output logic seq_idle,
  output logic wr_done
);

  localparam int LAT_W = $clog2(MIN_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(MIN_LAT - 2);

  seq_state_e state_q, state_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic lat_we;

  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    lat_we  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_WAIT;
          lat_d   = LAT_LOAD;
          lat_we  = 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (!chan_en) begin
          state_d = SEQ_IDLE;
        end else if (lat_q == '0) begin
          state_d = SEQ_READ;
        end else begin
          lat_d  = lat_q - 1'b1;
          lat_we = 1'b1;
        end
      end
      SEQ_READ: begin
        if (rd_ack) begin
          state_d = chan_en ? SEQ_WRITE : SEQ_IDLE;
        end
      end
      SEQ_WRITE: begin
        if (wr_ack) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (lat_we) begin
        lat_q <= lat_d;
      end
    end
  end

  assign rd_req   = (state_q == SEQ_READ);
  assign wr_req   = (state_q == SEQ_WRITE);
  assign seq_idle = (state_q == SEQ_IDLE);
  assign wr_done  = (state_q == SEQ_WRITE) & wr_ack;

endmodule

// File: rtl/dma_xfer_count.sv
// Channel enable, remaining-count and done flag.
module dma_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic [CNT_W-1:0] count_load,
  input  logic             seq_idle,
  input  logic             wr_done,
  output logic             chan_en,
  output logic             xfer_done,
  output logic             arm_load
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic en_q, en_d;
  logic done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_we;
  logic take_en;

  assign take_en = en_wr & en_wdata & ~en_q & seq_idle & (count_load != '0);
  assign cnt_we  = take_en | wr_done;

  always_comb begin
    en_d   = en_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    if (take_en) begin
      en_d   = 1'b1;
      done_d = 1'b0;
      cnt_d  = count_load;
    end else begin
      if (en_wr && !en_wdata) begin
        en_d = 1'b0;
      end
      if (wr_done) begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          en_d   = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      if (cnt_we) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign chan_en   = en_q;
  assign xfer_done = done_q;
  assign arm_load  = take_en;

endmodule

// File: rtl/dma_edge_req_ctrl.sv
module dma_edge_req_ctrl #(
  parameter int CNT_W   = 16,
  parameter int MIN_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic [CNT_W-1:0] count_load,
  input  logic             dreq_n,
  output logic             rd_req,
  input  logic             rd_ack,
  output logic             wr_req,
  input  logic             wr_ack,
  output logic             req_pending,
  output logic             chan_en,
  output logic             xfer_done
);

  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       seq_idle;
  logic       wr_done;
  logic       arm_load;
  logic       activate;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  dma_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .count_load (count_load),
    .seq_idle   (seq_idle),
    .wr_done    (wr_done),
    .chan_en    (chan_en),
    .xfer_done  (xfer_done),
    .arm_load   (arm_load)
  );

  dma_req_latch u_latch (
    .clk         (clk),
    .rst_n       (srst_n),
    .chan_en     (chan_en),
    .seq_idle    (seq_idle),
    .arm_load    (arm_load),
    .dreq_n      (dreq_n),
    .req_pending (req_pending),
    .activate    (activate)
  );

  dma_cycle_seq #(.MIN_LAT(MIN_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (activate),
    .chan_en  (chan_en),
    .rd_ack   (rd_ack),
    .wr_ack   (wr_ack),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .seq_idle (seq_idle),
    .wr_done  (wr_done)
  );

endmodule

// File: rtl/dma_edge_req_ctrl_chk.sv
module dma_edge_req_ctrl_chk #(
  parameter int MIN_LAT = 3
) (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_ack,
  input logic wr_req,
  input logic wr_ack,
  input logic req_pending,
  input logic chan_en,
  input logic xfer_done
);

  logic [7:0] lat_cnt;

  // edges elapsed since the last edge that left a request pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= 8'd0;
    end else if (req_pending) begin
      lat_cnt <= 8'd1;
    end else if (lat_cnt != 8'd0 && lat_cnt != 8'hff) begin
      lat_cnt <= lat_cnt + 8'd1;
    end
  end

  // R2
  off_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !req_pending);

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |=> !req_pending);

  // R5
  min_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> (int'(lat_cnt) >= MIN_LAT));

  // R6
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && chan_en) |=> wr_req);

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> !req_pending);

  // R8
  done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !chan_en);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

endmodule

bind dma_edge_req_ctrl dma_edge_req_ctrl_chk #(.MIN_LAT(MIN_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .wr_req      (wr_req),
  .wr_ack      (wr_ack),
  .req_pending (req_pending),
  .chan_en     (chan_en),
  .xfer_done   (xfer_done)
);

// File: tb/dma_edge_req_ctrl_test.sv
`timescale 1ns/1ps
module dma_edge_req_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        en_wr;
  logic        en_wdata;
  logic [15:0] count_load;
  logic        dreq_n;
  logic        rd_req;
  logic        rd_ack;
  logic        wr_req;
  logic        wr_ack;
  logic        req_pending;
  logic        chan_en;
  logic        xfer_done;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_wait = 0;
  int wr_wait = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  bit finished = 0;
  byte exp_q[$];

  dma_edge_req_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .count_load(count_load), .dreq_n(dreq_n), .rd_req(rd_req),
    .rd_ack(rd_ack), .wr_req(wr_req), .wr_ack(wr_ack),
    .req_pending(req_pending), .chan_en(chan_en), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_xfer(input bit with_write);
    exp_q.push_back("R");
    if (with_write) exp_q.push_back("W");
  endtask

  task automatic sb_pop(input byte kind);
    byte e;
    n_tests++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R6 unexpected handshake: actual %0d expected %0d", kind, 0);
    end else begin
      e = exp_q.pop_front();
      if (e != kind) begin
        n_fail++;
        $display("FAIL R6 handshake order: actual %0d expected %0d", kind, e);
      end
    end
  endtask

  // monitor / responder: acknowledges strobes and scores them
  initial begin
    rd_ack = 1'b0;
    wr_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req) begin
        if (rd_cnt >= rd_wait) begin
          rd_ack = 1'b1;
          rd_cnt = 0;
          sb_pop("R");
        end else begin
          rd_cnt++;
        end
      end else if (rd_cnt != 0) begin
        check(1'b0, "R9 read strobe dropped early", 0, 1);
        rd_cnt = 0;
      end
      if (wr_ack) begin
        wr_ack = 1'b0;
      end else if (wr_req) begin
        if (wr_cnt >= wr_wait) begin
          wr_ack = 1'b1;
          wr_cnt = 0;
          sb_pop("W");
        end else begin
          wr_cnt++;
        end
      end else if (wr_cnt != 0) begin
        check(1'b0, "R9 write strobe dropped early", 0, 1);
        wr_cnt = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_wr = 1'b0; en_wdata = 1'b0; count_load = '0; dreq_n = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R1
    check(!rd_req && !wr_req && !req_pending && !chan_en && !xfer_done,
          "R1 reset outputs", {rd_req, wr_req, req_pending, chan_en, xfer_done}, 0);

    // R2: low line before enable is ignored
    dreq_n = 1'b0;
    tick(4);
    check(!req_pending, "R2 no latch while disabled", req_pending, 0);

    // R3/R4/R5: enable with line already low, count 4
    rd_wait = 2; wr_wait = 1;
    push_xfer(1);
    en_wr = 1'b1; en_wdata = 1'b1; count_load = 16'd4;
    tick();
    en_wr = 1'b0;
    check(chan_en == 1'b1, "R3 enable set", chan_en, 1);
    check(!req_pending, "R3 no sample on enable edge", req_pending, 0);
    tick();
    check(req_pending == 1'b1, "R3 latch on next edge", req_pending, 1);
    tick();
    check(!req_pending, "R4 request cleared on activation", req_pending, 0);
    check(!rd_req, "R5 read not yet (edge 1)", rd_req, 0);
    tick();
    check(!rd_req, "R5 read not yet (edge 2)", rd_req, 0);
    tick();
    check(rd_req == 1'b1, "R5 read after three edges", rd_req, 1);

    // R7: line held low, no second transfer
    tick(40);
    check(!req_pending && !rd_req, "R7 held low gives no repeat", req_pending, 0);
    check(exp_q.size() == 0, "R7 one transfer only", exp_q.size(), 0);

    // R6: high then low re-arms
    push_xfer(1);
    dreq_n = 1'b1;
    tick();
    dreq_n = 1'b0;
    tick();
    check(req_pending == 1'b1, "R6 re-arm after high", req_pending, 1);
    tick(40);

    // R6/R8: high during transfer, low before write end => back-to-back, then terminal
    rd_wait = 6; wr_wait = 2;
    push_xfer(1);
    push_xfer(1);
    dreq_n = 1'b1;
    tick();
    dreq_n = 1'b0;
    tick(4);
    dreq_n = 1'b1;
    tick();
    dreq_n = 1'b0;
    tick(60);
    check(exp_q.size() == 0, "R6 mid-transfer high re-arms", exp_q.size(), 0);
    check(xfer_done == 1'b1, "R8 done at count zero", xfer_done, 1);
    check(!chan_en, "R8 enable cleared at count zero", chan_en, 0);
    dreq_n = 1'b1;
    tick();
    dreq_n = 1'b0;
    tick(10);
    check(!req_pending && !rd_req, "R8 no transfer after done", rd_req, 0);

    // R9/R11: re-enable, long wait states
    rd_wait = 7; wr_wait = 5;
    dreq_n = 1'b1;
    en_wr = 1'b1; en_wdata = 1'b1; count_load = 16'd5;
    tick();
    en_wr = 1'b0;
    check(!xfer_done && chan_en, "R11 enable clears done", xfer_done, 0);
    push_xfer(1);
    dreq_n = 1'b0;
    tick(45);
    check(exp_q.size() == 0, "R9 transfer with wait states", exp_q.size(), 0);

    // R10: abort during read
    push_xfer(0);
    dreq_n = 1'b1;
    tick();
    dreq_n = 1'b0;
    for (int i = 0; i < 20 && !rd_req; i++) tick();
    check(rd_req == 1'b1, "R10 read started before abort", rd_req, 1);
    en_wr = 1'b1; en_wdata = 1'b0;
    tick();
    en_wr = 1'b0;
    check(!chan_en, "R10 disable clears enable", chan_en, 0);
    tick(30);
    check(exp_q.size() == 0 && !wr_req, "R10 read completes, no write", exp_q.size(), 0);
    check(!req_pending, "R10 nothing pending after abort", req_pending, 0);

    // R11: zero count refused
    en_wr = 1'b1; en_wdata = 1'b1; count_load = 16'd0;
    tick();
    en_wr = 1'b0;
    check(!chan_en, "R11 zero count refused", chan_en, 0);
    tick(5);
    check(!req_pending, "R11 no request after refused enable", req_pending, 0);

    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule